// File: doc/BRIEF.md
# Operand-Snooping Reservation Station Bank

This block is a set of reservation stations for an out-of-order issue engine. Each functional unit has one station of its own. A station holds one instruction until that instruction has run: its opcode, two operand slots, and a busy flag. Each operand slot holds either a real value or the number of the station that will produce the value. The issue logic, which sits outside the block and does the renaming, picks a free station. It then writes the opcode into the station, together with either a real value (tag zero) or a producer tag for each operand.

A single result bus carries each finished result, marked with the number of the station that produced it. Every station watches this bus. A waiting operand whose tag matches the bus takes the value, and its tag is cleared to zero. Once both tags are zero and the unit is free, the station presents its instruction to the unit once. The station stays occupied until its own result appears on the bus.

The tag of a station is its position counted from one, so a tag of zero always means "value present".

Top module: `rs_bank`

## Requirements
- R1: `iss_ready` is high exactly when `iss_sel` names a station that is not busy. An issue presented while `iss_ready` is low is ignored, and the station keeps its earlier contents.
- R2: An accepted issue sets the station's busy flag on the next clock edge. Each operand is stored as given: a value with tag 0, or a nonzero producer tag.
- R3: `disp_valid[i]` is high only while station i is busy, both of its operand tags are zero, and `fu_free[i]` is high. It is held back while the unit is not free. While high, the station's opcode and its two operand values appear on its slice of `disp_op`, `disp_j` and `disp_k`.
- R4: A broadcast with tag t makes every busy station whose j tag equals t copy `bc_data` into j and clear that tag, on the next edge. The k operand is handled the same way and independently, so one broadcast can fill both operands.
- R5: A broadcast whose tag equals a busy station's own tag clears that station's busy flag on the next edge.
- R6: Station i (counting from 0) has tag i+1, and `iss_sel` uses the same numbering. A `iss_sel` of 0 or above NUM_ST names no station: `iss_ready` is low and nothing is written.
- R7: If an issued operand's tag matches a broadcast in the issue cycle, the station stores the broadcast value with tag 0.
- R8: A station raises `disp_valid` for exactly one cycle per issued instruction, even while the unit stays free.
- R9: After reset no station is busy and no `disp_valid` bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_sel | input | TAG_W | Target station number, 1..NUM_ST |
| iss_op | input | OP_W | Opcode to store |
| iss_j_tag | input | TAG_W | Producer tag of operand j, 0 if value given |
| iss_j_val | input | DATA_W | Value of operand j |
| iss_k_tag | input | TAG_W | Producer tag of operand k, 0 if value given |
| iss_k_val | input | DATA_W | Value of operand k |
| iss_ready | output | 1 | Target station is free |
| bc_valid | input | 1 | Result bus carries a result |
| bc_tag | input | TAG_W | Producing station number |
| bc_data | input | DATA_W | Result value |
| fu_free | input | NUM_ST | Per-unit free flag |
| busy | output | NUM_ST | Per-station busy flag |
| disp_valid | output | NUM_ST | Per-station dispatch strobe |
| disp_op | output | NUM_ST*OP_W | Dispatched opcodes, station i at slice i |
| disp_j | output | NUM_ST*DATA_W | Dispatched j operands |
| disp_k | output | NUM_ST*DATA_W | Dispatched k operands |

## Verification
The bench builds the block with its default values: four stations, 32-bit operands, a 2-bit opcode and 3-bit tags. With three tag bits, the codes 0 and 5 can be driven onto `iss_sel`, so both out-of-range selections are exercised. Four stations allow a chain in which one station's tag is pending in two others at once. In one scenario, a unit with a fixed latency is modelled in the bench. It feeds its result back over the bus, so that result both fills a dependent station and frees its own.

// File: rtl/rs_pkg.sv
package rs_pkg;
    localparam int DEF_NUM_ST = 4;
    localparam int DEF_DATA_W = 32;
    localparam int DEF_OP_W   = 2;

    typedef struct packed {
        logic busy;
        logic started;
    } rs_flags_t;
endpackage

// File: rtl/rs_opnd.sv
module rs_opnd #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              load_i,
    input  logic [TAG_W-1:0]  ld_tag_i,
    input  logic [DATA_W-1:0] ld_val_i,
    input  logic              live_i,
    input  logic [TAG_W-1:0]  cur_tag_i,
    input  logic [DATA_W-1:0] cur_val_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    output logic [TAG_W-1:0]  nxt_tag_o,
    output logic [DATA_W-1:0] nxt_val_o
);
    logic hit_ld;
    logic hit_cur;

    always_comb begin
        hit_ld    = bc_valid_i && (ld_tag_i != '0) && (bc_tag_i == ld_tag_i);
        hit_cur   = bc_valid_i && live_i && (cur_tag_i != '0) && (bc_tag_i == cur_tag_i);
        nxt_tag_o = cur_tag_i;
        nxt_val_o = cur_val_i;
        if (load_i) begin
            if (hit_ld) begin
                nxt_tag_o = '0;
                nxt_val_o = bc_data_i;
            end else begin
                nxt_tag_o = ld_tag_i;
                nxt_val_o = ld_val_i;
            end
        end else if (hit_cur) begin
            nxt_tag_o = '0;
            nxt_val_o = bc_data_i;
        end
    end
endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
    parameter int DATA_W = 32,
    parameter int OP_W   = 2,
    parameter int TAG_W  = 3,
    parameter int IDX    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [TAG_W-1:0]  jt_i,
    input  logic [DATA_W-1:0] jv_i,
    input  logic [TAG_W-1:0]  kt_i,
    input  logic [DATA_W-1:0] kv_i,
    input  logic              bc_valid_i,
    input  logic [TAG_W-1:0]  bc_tag_i,
    input  logic [DATA_W-1:0] bc_data_i,
    input  logic              fu_free_i,
    output logic              busy_o,
    output logic              disp_valid_o,
    output logic [OP_W-1:0]   disp_op_o,
    output logic [DATA_W-1:0] disp_j_o,
    output logic [DATA_W-1:0] disp_k_o
);
    import rs_pkg::*;

    localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(IDX);

    typedef struct packed {
        rs_flags_t         fl;
        logic [OP_W-1:0]   op;
        logic [TAG_W-1:0]  qj;
        logic [DATA_W-1:0] vj;
        logic [TAG_W-1:0]  qk;
        logic [DATA_W-1:0] vk;
    } ent_t;

    ent_t st_d, st_q;
    logic [TAG_W-1:0]  qj_n, qk_n;
    logic [DATA_W-1:0] vj_n, vk_n;
    logic              fire;
    logic              own_bc;

    rs_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_j (
        .load_i(issue_i), .ld_tag_i(jt_i), .ld_val_i(jv_i),
        .live_i(st_q.fl.busy), .cur_tag_i(st_q.qj), .cur_val_i(st_q.vj),
        .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
        .nxt_tag_o(qj_n), .nxt_val_o(vj_n)
    );

    rs_opnd #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_opnd_k (
        .load_i(issue_i), .ld_tag_i(kt_i), .ld_val_i(kv_i),
        .live_i(st_q.fl.busy), .cur_tag_i(st_q.qk), .cur_val_i(st_q.vk),
        .bc_valid_i(bc_valid_i), .bc_tag_i(bc_tag_i), .bc_data_i(bc_data_i),
        .nxt_tag_o(qk_n), .nxt_val_o(vk_n)
    );

    always_comb begin
        fire   = st_q.fl.busy && !st_q.fl.started && (st_q.qj == '0)
                 && (st_q.qk == '0) && fu_free_i;
        own_bc = bc_valid_i && (bc_tag_i == MY_TAG) && st_q.fl.busy;
        st_d    = st_q;
        st_d.qj = qj_n;
        st_d.vj = vj_n;
        st_d.qk = qk_n;
        st_d.vk = vk_n;
        if (fire) st_d.fl.started = 1'b1;
        if (issue_i) begin
            st_d.fl.busy    = 1'b1;
            st_d.fl.started = 1'b0;
            st_d.op         = op_i;
        end else if (own_bc) begin
            st_d.fl.busy    = 1'b0;
            st_d.fl.started = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy_o       = st_q.fl.busy;
    assign disp_valid_o = fire;
    assign disp_op_o    = st_q.op;
    assign disp_j_o     = st_q.vj;
    assign disp_k_o     = st_q.vk;

    AST_ISSUE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |=> busy_o); // R2
    AST_OWN_BC_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && bc_valid_i && bc_tag_i == MY_TAG) |=> !busy_o); // R5
    AST_J_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_i && bc_valid_i && st_q.qj != '0 && bc_tag_i == st_q.qj)
        |=> (st_q.qj == '0 && disp_j_o == $past(bc_data_i))); // R4
    AST_K_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !issue_i && bc_valid_i && st_q.qk != '0 && bc_tag_i == st_q.qk)
        |=> (st_q.qk == '0 && disp_k_o == $past(bc_data_i))); // R4
    AST_NO_REDISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |=> !disp_valid_o); // R8
    AST_DISP_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid_o |-> (busy_o && fu_free_i)); // R3
endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
    parameter int NUM_ST = rs_pkg::DEF_NUM_ST,
    parameter int DATA_W = rs_pkg::DEF_DATA_W,
    parameter int OP_W   = rs_pkg::DEF_OP_W,
    parameter int TAG_W  = $clog2(NUM_ST + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     iss_valid,
    input  logic [TAG_W-1:0]         iss_sel,
    input  logic [OP_W-1:0]          iss_op,
    input  logic [TAG_W-1:0]         iss_j_tag,
    input  logic [DATA_W-1:0]        iss_j_val,
    input  logic [TAG_W-1:0]         iss_k_tag,
    input  logic [DATA_W-1:0]        iss_k_val,
    output logic                     iss_ready,
    input  logic                     bc_valid,
    input  logic [TAG_W-1:0]         bc_tag,
    input  logic [DATA_W-1:0]        bc_data,
    input  logic [NUM_ST-1:0]        fu_free,
    output logic [NUM_ST-1:0]        busy,
    output logic [NUM_ST-1:0]        disp_valid,
    output logic [NUM_ST*OP_W-1:0]   disp_op,
    output logic [NUM_ST*DATA_W-1:0] disp_j,
    output logic [NUM_ST*DATA_W-1:0] disp_k
);
    logic [NUM_ST-1:0] hit_sel;
    logic [NUM_ST-1:0] issue_vec;

    always_comb begin
        iss_ready = 1'b0;
        for (int i = 0; i < NUM_ST; i++) begin
            hit_sel[i] = (iss_sel == TAG_W'(i + 1));
            if (hit_sel[i] && !busy[i]) iss_ready = 1'b1;
        end
        issue_vec = (iss_valid && iss_ready) ? hit_sel : '0;
    end

    for (genvar g = 0; g < NUM_ST; g++) begin : g_st
        rs_entry #(.DATA_W(DATA_W), .OP_W(OP_W), .TAG_W(TAG_W), .IDX(g + 1)) u_ent (
            .clk(clk), .rst_n(rst_n),
            .issue_i(issue_vec[g]), .op_i(iss_op),
            .jt_i(iss_j_tag), .jv_i(iss_j_val),
            .kt_i(iss_k_tag), .kv_i(iss_k_val),
            .bc_valid_i(bc_valid), .bc_tag_i(bc_tag), .bc_data_i(bc_data),
            .fu_free_i(fu_free[g]),
            .busy_o(busy[g]), .disp_valid_o(disp_valid[g]),
            .disp_op_o(disp_op[g*OP_W +: OP_W]),
            .disp_j_o(disp_j[g*DATA_W +: DATA_W]),
            .disp_k_o(disp_k[g*DATA_W +: DATA_W])
        );
    end

    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_vec)); // R6
    AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !bc_valid) |=> $stable(busy)); // R1
endmodule

// File: tb/rs_bank_tb.sv
`timescale 1ns/1ps
module rs_bank_tb;
    localparam int NS = 4;
    localparam int DW = 32;
    localparam int OW = 2;
    localparam int TW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iss_valid = 1'b0;
    logic [TW-1:0] iss_sel = '0;
    logic [OW-1:0] iss_op = '0;
    logic [TW-1:0] iss_j_tag = '0, iss_k_tag = '0;
    logic [DW-1:0] iss_j_val = '0, iss_k_val = '0;
    logic iss_ready;
    logic bc_valid = 1'b0;
    logic [TW-1:0] bc_tag = '0;
    logic [DW-1:0] bc_data = '0;
    logic [NS-1:0] fu_free = '1;
    logic [NS-1:0] busy, disp_valid;
    logic [NS*OW-1:0] disp_op;
    logic [NS*DW-1:0] disp_j, disp_k;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    rs_bank u_dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_sel(iss_sel),
        .iss_op(iss_op), .iss_j_tag(iss_j_tag), .iss_j_val(iss_j_val),
        .iss_k_tag(iss_k_tag), .iss_k_val(iss_k_val), .iss_ready(iss_ready),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .fu_free(fu_free), .busy(busy), .disp_valid(disp_valid),
        .disp_op(disp_op), .disp_j(disp_j), .disp_k(disp_k)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic issue(input int sel, input int op, input int jt, input int jv,
                         input int kt, input int kv);
        iss_valid = 1'b1; iss_sel = TW'(sel); iss_op = OW'(op);
        iss_j_tag = TW'(jt); iss_j_val = DW'(jv);
        iss_k_tag = TW'(kt); iss_k_val = DW'(kv);
        tick();
        iss_valid = 1'b0;
    endtask

    task automatic bcast(input int tag, input int data);
        bc_valid = 1'b1; bc_tag = TW'(tag); bc_data = DW'(data);
        tick();
        bc_valid = 1'b0;
    endtask

    function automatic logic [DW-1:0] jv(input int s); return disp_j[s*DW +: DW]; endfunction
    function automatic logic [DW-1:0] kv(input int s); return disp_k[s*DW +: DW]; endfunction
    function automatic logic [OW-1:0] opv(input int s); return disp_op[s*OW +: OW]; endfunction

    task automatic t_reset();
        chk("R9 busy after reset", busy, 0);
        chk("R9 dispatch after reset", disp_valid, 0);
    endtask

    task automatic t_basic();
        issue(1, 2, 0, 10, 0, 20);
        chk("R2 busy set", busy[0], 1);
        chk("R3 dispatch ready", disp_valid[0], 1);
        chk("R3 op", opv(0), 2);
        chk("R3 j", jv(0), 10);
        chk("R3 k", kv(0), 20);
        tick();
        chk("R8 single dispatch", disp_valid[0], 0);
        iss_sel = 3'd1; #0.1;
        chk("R1 ready low on busy", iss_ready, 0);
        bcast(1, 0);
        chk("R5 freed", busy[0], 0);
        iss_sel = 3'd1; #0.1;
        chk("R1 ready high on free", iss_ready, 1);
    endtask

    task automatic t_wait_j();
        issue(2, 1, 3, 0, 0, 7);
        chk("R2 pending busy", busy[1], 1);
        chk("R3 held on tag", disp_valid[1], 0);
        bcast(4, 111);
        chk("R4 other tag ignored", disp_valid[1], 0);
        bcast(3, 55);
        chk("R4 j captured dispatch", disp_valid[1], 1);
        chk("R4 j value", jv(1), 55);
        chk("R4 k kept", kv(1), 7);
        bcast(2, 0);
        chk("R5 freed st2", busy[1], 0);
    endtask

    task automatic t_both();
        issue(3, 3, 1, 0, 2, 0);
        issue(4, 0, 1, 0, 1, 0);
        bcast(2, 9);
        chk("R4 k only not ready", disp_valid[2], 0);
        bcast(1, 4);
        chk("R4 both filled", disp_valid[3:2], 2'b11);
        chk("R4 st3 j", jv(2), 4);
        chk("R4 st3 k", kv(2), 9);
        chk("R4 st4 j", jv(3), 4);
        chk("R4 st4 k", kv(3), 4);
        bcast(3, 0);
        bcast(4, 0);
        chk("R5 all free", busy, 0);
    endtask

    task automatic t_fu_hold_and_stall();
        fu_free[0] = 1'b0;
        issue(1, 1, 0, 1, 0, 2);
        for (int i = 0; i < 3; i++) begin
            chk("R3 unit busy holds", disp_valid[0], 0);
            tick();
        end
        iss_sel = 3'd1; #0.1;
        chk("R1 ready low", iss_ready, 0);
        issue(1, 3, 0, 99, 0, 98);
        fu_free[0] = 1'b1; #0.1;
        chk("R3 dispatch when free", disp_valid[0], 1);
        chk("R1 stalled op ignored", opv(0), 1);
        chk("R1 stalled j ignored", jv(0), 1);
        chk("R1 stalled k ignored", kv(0), 2);
        tick();
        chk("R8 once after free", disp_valid[0], 0);
        bcast(1, 0);
    endtask

    task automatic t_same_cycle();
        bc_valid = 1'b1; bc_tag = 3'd4; bc_data = 32'd123;
        issue(2, 2, 4, 0, 3, 0);
        bc_valid = 1'b0;
        chk("R7 k still pending", disp_valid[1], 0);
        bcast(3, 5);
        chk("R7 ready after k", disp_valid[1], 1);
        chk("R7 j from issue-cycle bus", jv(1), 123);
        bcast(2, 0);
    endtask

    task automatic t_range();
        iss_sel = 3'd0; #0.1;
        chk("R6 sel 0 not ready", iss_ready, 0);
        iss_sel = 3'd5; #0.1;
        chk("R6 sel 5 not ready", iss_ready, 0);
        issue(0, 1, 0, 1, 0, 1);
        chk("R6 sel 0 no write", busy, 0);
        issue(5, 1, 0, 1, 0, 1);
        chk("R6 sel 5 no write", busy, 0);
    endtask

    task automatic t_fu_chain();
        logic [DW-1:0] res;
        issue(1, 0, 0, 3, 0, 4);
        issue(2, 0, 1, 0, 0, 10);
        res = jv(0) + kv(0);
        tick(); tick();
        chk("R5 producer busy while computing", busy[0], 1);
        bcast(1, int'(res));
        chk("R5 producer freed", busy[0], 0);
        chk("R4 consumer ready", disp_valid[1], 1);
        chk("R4 consumer j", jv(1), 7);
        bcast(2, 17);
        chk("R5 consumer freed", busy[1], 0);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_basic();
        t_wait_j();
        t_both();
        t_fu_hold_and_stall();
        t_same_cycle();
        t_range();
        t_fu_chain();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule